// File: doc/BRIEF.md
# Variable-Width Saturating Clamp

This block limits a 32-bit two's-complement operand to a range whose size is picked on every operation by a 5-bit width operand `w`. There are two modes. In signed mode the allowed range runs from -2^w up to 2^w-1. In unsigned mode it runs from 0 up to 2^w-1.

An operand is presented with a one-cycle valid strobe. The clamped value comes out of an output register on the next cycle. It arrives together with a flag that says whether this operation was clamped. A sticky flag collects every clamp event since it was last cleared, so a datapath can run a block of operations and then ask once whether any of them saturated.

Top module: `sat_range_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid`, `out_data`, `out_clamped` and `out_sticky` to zero. They stay at zero after reset until the first operation.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high at the clock edge. Otherwise it is low.
- R3: In signed mode (`in_signed` = 1), an operand whose signed value is above 2^w-1 produces 2^w-1.
- R4: In signed mode, an operand whose signed value is below -2^w produces -2^w, in 32-bit two's complement.
- R5: In unsigned mode (`in_signed` = 0), an operand with bit 31 set (a negative value) produces 0.
- R6: In unsigned mode, a non-negative operand above 2^w-1 produces 2^w-1.
- R7: An operand already inside the range of its mode passes to `out_data` unchanged, and `out_clamped` is low.
- R8: `out_clamped` is high with a result exactly when R3, R4, R5 or R6 applied to that operation.
- R9: `out_sticky` rises on the edge that registers a clamped result. It stays high through later operations that are not clamped.
- R10: `sticky_clr` high at an edge clears `out_sticky`. If a clamped operation is registered at the same edge, the flag is set instead, because a new clamp event wins over the clear.
- R11: All widths from 0 to 31 are legal. With w = 0, signed mode allows only -1 and 0 and unsigned mode allows only 0. With w = 31, signed mode never clamps and unsigned mode clamps only negative operands.
- R12: In cycles without `in_valid`, `out_data` and `out_clamped` keep the last registered result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 32 | Operand, two's complement |
| in_width | input | 5 | Range width w (0..31) |
| in_signed | input | 1 | 1 = signed range, 0 = unsigned range |
| sticky_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 32 | Clamped result |
| out_clamped | output | 1 | This result was clamped |
| out_sticky | output | 1 | Any clamp since the last clear |

## Verification
The bench aims at the range edges for every width.

- **Boundary values:** it drives 2^w-1, 2^w, -2^w and -2^w-1. A design with an off-by-one in its bound compare would clamp a legal value, or let an illegal value through.
- **Extreme widths:** it covers w = 0 and w = 31. A design that built its mask with a shift of the wrong size would wrap at these widths.
- **Unsigned mode:** it applies large negative operands. A design that compared them as unsigned would return the mask instead of zero.
- **Sticky flag:** it asserts the clear in the same cycle as a clamped operation. A design that gave the clear priority would lose that event.

// File: rtl/sat_pkg.sv
// Package sat_pkg
// Shared types for the saturating clamp.
// Assumes a single clock domain and a data width of at least 2 bits.
package sat_pkg;

    // Range mode; the value matches the in_signed port encoding.
    typedef enum logic {
        SAT_MODE_UNSIGNED = 1'b0,
        SAT_MODE_SIGNED   = 1'b1
    } sat_mode_e;

    // Per-operation clamp decision produced by the range detector.
    typedef struct packed {
        logic over_hi;   // operand above the upper bound
        logic under_lo;  // operand below the lower bound
    } sat_flags_t;

endpackage : sat_pkg

// File: rtl/sat_limit_gen.sv
// Module sat_limit_gen
// Builds the limit mask 2^w-1 from the run-time width operand.
// Assumes width values up to DATA_W-1; each mask bit is one compare.
module sat_limit_gen #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic [SEL_W-1:0]  width,
    output logic [DATA_W-1:0] lim_mask
);

    // Bit g of the mask is set when g lies below the selected width.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask_bit
        localparam logic [SEL_W:0] BIT_IDX = (SEL_W+1)'(g);
        assign lim_mask[g] = ({1'b0, width} > BIT_IDX);
    end

endmodule : sat_limit_gen

// File: rtl/sat_range_detect.sv
// Module sat_range_detect
// Decides whether an operand lies above or below the selected range.
//
// Signed mode: the operand is shifted arithmetically right by w.
// - A positive remainder means the operand is above the upper bound.
// - A remainder below -1 means it is below the lower bound.
// Unsigned mode: a negative operand is below the range. Any bit set outside
// the mask on a non-negative operand puts it above the range.
// Purely combinational.
module sat_range_detect
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic [SEL_W-1:0]  width,
    input  logic [DATA_W-1:0] lim_mask,
    input  sat_mode_e         mode,
    output sat_flags_t        flags
);

    localparam int MSB = DATA_W - 1;

    logic signed [DATA_W-1:0] shifted;
    logic                     sg_hi;
    logic                     sg_lo;
    logic                     us_neg;
    logic                     us_hi;

    // Arithmetic shift exposes the bits that lie above the signed range.
    always_comb shifted = $signed(value) >>> width;

    // The remainder is positive when its sign is clear and any bit is set.
    always_comb sg_hi = !shifted[MSB] && (|shifted);

    // The remainder is below -1 when its sign is set and it is not all ones.
    always_comb sg_lo = shifted[MSB] && !(&shifted);

    // Unsigned mode: the sign bit alone marks an operand below zero.
    always_comb us_neg = value[MSB];

    // Unsigned mode: a non-negative operand with bits outside the mask is too large.
    always_comb us_hi = !value[MSB] && (|(value & ~lim_mask));

    // Select the decision of the active mode.
    always_comb begin
        if (mode == SAT_MODE_SIGNED) begin
            flags.over_hi  = sg_hi;
            flags.under_lo = sg_lo;
        end else begin
            flags.over_hi  = us_hi;
            flags.under_lo = us_neg;
        end
    end

endmodule : sat_range_detect

// File: rtl/sat_clamp_mux.sv
// Module sat_clamp_mux
// Picks the result from the operand, the upper bound or the lower bound.
// The upper bound is always the mask. The lower bound is the inverted mask
// in signed mode and zero in unsigned mode. Assumes the detector never
// raises both flags at once.
module sat_clamp_mux
    import sat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lim_mask,
    input  sat_mode_e         mode,
    input  sat_flags_t        flags,
    output logic [DATA_W-1:0] result,
    output logic              clamped
);

    logic [DATA_W-1:0] low_bound;

    // Lower bound per mode: -2^w in signed mode, zero in unsigned mode.
    always_comb low_bound = (mode == SAT_MODE_SIGNED) ? ~lim_mask : '0;

    // Three-way select of the clamped value.
    always_comb begin
        if (flags.over_hi)
            result = lim_mask;
        else if (flags.under_lo)
            result = low_bound;
        else
            result = value;
    end

    // Any limit hit counts as a clamp for this operation.
    always_comb clamped = flags.over_hi | flags.under_lo;

endmodule : sat_clamp_mux

// File: rtl/sat_sticky.sv
// Module sat_sticky
// Collects clamp events into a flag that holds until it is cleared.
// A clamp event in the same cycle as a clear leaves the flag set.
// Synchronous active-low reset.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic event_in,
    output logic flag
);

    // Hold the flag; a clear drops it unless a new event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= (flag & ~clr) | event_in;
    end

endmodule : sat_sticky

// File: rtl/sat_range_unit.sv
// Module sat_range_unit (top)
// Run-time width saturating clamp with a registered result and a sticky
// clamp flag. The result appears one cycle after in_valid and is held
// between operations. Assumes in_width is stable while in_valid is high.
// Synchronous active-low reset.
module sat_range_unit
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [SEL_W-1:0]  in_width,
    input  logic              in_signed,
    input  logic              sticky_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_clamped,
    output logic              out_sticky
);

    sat_mode_e         mode;
    logic [DATA_W-1:0] lim_mask;
    sat_flags_t        flags;
    logic [DATA_W-1:0] clamp_val;
    logic              clamp_hit;

    // Map the mode port onto the package enum.
    always_comb mode = sat_mode_e'(in_signed);

    sat_limit_gen #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_limit (
        .width    (in_width),
        .lim_mask (lim_mask)
    );

    sat_range_detect #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_detect (
        .value    (in_value),
        .width    (in_width),
        .lim_mask (lim_mask),
        .mode     (mode),
        .flags    (flags)
    );

    sat_clamp_mux #(.DATA_W(DATA_W)) u_mux (
        .value    (in_value),
        .lim_mask (lim_mask),
        .mode     (mode),
        .flags    (flags),
        .result   (clamp_val),
        .clamped  (clamp_hit)
    );

    sat_sticky u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sticky_clr),
        .event_in (in_valid & clamp_hit),
        .flag     (out_sticky)
    );

    // Result strobe: follows in_valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Result register: loads on a valid operand and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_clamped <= 1'b0;
        end else if (in_valid) begin
            out_data    <= clamp_val;
            out_clamped <= clamp_hit;
        end
    end

endmodule : sat_range_unit

// File: rtl/sat_range_unit_chk.sv
// Module sat_range_unit_chk
// Property checker for sat_range_unit, attached with bind. It keeps its own
// copy of the previous cycle's operand and computes the bounds with 64-bit
// integer arithmetic.
module sat_range_unit_chk #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_value,
    input logic [SEL_W-1:0]  in_width,
    input logic              in_signed,
    input logic              sticky_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_clamped,
    input logic              out_sticky
);

    logic [DATA_W-1:0] cap_value;
    logic [SEL_W-1:0]  cap_width;
    logic              cap_signed;
    logic              cap_vld;
    logic              cap_clr;
    longint            cap_v;
    longint            cap_lim;
    longint            cap_low;

    // Capture each cycle's inputs for comparison one cycle later.
    always_ff @(posedge clk) begin
        cap_value  <= in_value;
        cap_width  <= in_width;
        cap_signed <= in_signed;
        cap_vld    <= in_valid && rst_n;
        cap_clr    <= sticky_clr;
    end

    // Integer view of the captured operand and its signed bounds.
    always_comb begin
        cap_v   = longint'($signed(cap_value));
        cap_lim = (longint'(1) <<< cap_width) - longint'(1);
        cap_low = -cap_lim - longint'(1);
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == cap_vld);

    assert_signed_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_signed && cap_v > cap_lim) |-> out_data == DATA_W'(cap_lim));

    assert_signed_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_signed && cap_v < cap_low) |-> out_data == DATA_W'(cap_low));

    assert_unsigned_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cap_signed && cap_v < 0) |-> out_data == '0);

    assert_unsigned_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cap_signed && cap_v > cap_lim) |-> out_data == DATA_W'(cap_lim));

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_clamped) |-> out_data == cap_value);

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_clamped) |-> out_sticky);

    assert_sticky_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_sticky) |-> cap_clr);

endmodule : sat_range_unit_chk

bind sat_range_unit sat_range_unit_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_value    (in_value),
    .in_width    (in_width),
    .in_signed   (in_signed),
    .sticky_clr  (sticky_clr),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_clamped (out_clamped),
    .out_sticky  (out_sticky)
);

// File: tb/sat_range_unit_tb.sv
`timescale 1ns/1ps
module sat_range_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [4:0]  in_width = '0;
    logic        in_signed = 1'b0;
    logic        sticky_clr = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_clamped;
    logic        out_sticky;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state.
    bit          m_valid = 0;
    logic [31:0] m_data = '0;
    bit          m_clamped = 0;
    bit          m_sticky = 0;
    string       m_tag = "R1";
    bit          m_clr_seen = 0;

    always #2 clk = ~clk;

    sat_range_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_width(in_width), .in_signed(in_signed), .sticky_clr(sticky_clr),
        .out_valid(out_valid), .out_data(out_data), .out_clamped(out_clamped),
        .out_sticky(out_sticky)
    );

    // Behavioural model: integer range arithmetic, updated every edge.
    always @(posedge clk) begin
        longint v, hi, lo;
        if (!rst_n) begin
            m_valid = 0; m_data = '0; m_clamped = 0; m_sticky = 0;
            m_tag = "R1"; m_clr_seen = 0;
        end else begin
            m_valid = in_valid;
            m_clr_seen = sticky_clr;
            if (sticky_clr) m_sticky = 0;
            if (in_valid) begin
                v  = longint'($signed(in_value));
                hi = (longint'(1) <<< in_width) - 1;
                lo = in_signed ? -hi - 1 : 0;
                m_clamped = 1;
                if (v > hi) begin
                    m_data = 32'(hi);
                    m_tag = in_signed ? "R3" : "R6";
                end else if (v < lo) begin
                    m_data = 32'(lo);
                    m_tag = in_signed ? "R4" : "R5";
                end else begin
                    m_data = in_value;
                    m_clamped = 0;
                    m_tag = "R7";
                end
                if (in_width == 0 || in_width == 31) m_tag = {m_tag, "/R11"};
                if (m_clamped) m_sticky = 1;
            end else begin
                m_tag = "R12";
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge, every cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 valid", 32'(out_valid), 32'(m_valid));
            check({m_tag, " data"}, out_data, m_data);
            check(m_valid ? "R8 clamped" : "R12 clamped", 32'(out_clamped), 32'(m_clamped));
            check(m_clr_seen ? "R10 sticky" : "R9 sticky", 32'(out_sticky), 32'(m_sticky));
        end
    end

    task automatic op(input logic [31:0] v, input int w, input bit s, input bit clr = 0);
        @(negedge clk);
        in_valid = 1; in_value = v; in_width = 5'(w); in_signed = s; sticky_clr = clr;
        @(negedge clk);
        in_valid = 0; sticky_clr = 0;
    endtask

    task automatic idle(input int n, input bit clr = 0);
        @(negedge clk);
        sticky_clr = clr; in_value = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
        sticky_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state seen at the ports.
        check("R1 valid", 32'(out_valid), 0);
        check("R1 data", out_data, 0);
        check("R1 sticky", 32'(out_sticky), 0);
        // Pass-through inside the range, sticky stays low.
        op(32'd100, 8, 1);
        op(32'hFFFF_FF00, 8, 1);
        // Signed upper and lower boundaries (R3, R4).
        for (int w = 0; w < 32; w++) begin
            longint h = (longint'(1) <<< w) - 1;
            op(32'(h), w, 1);
            op(32'(h + 1), w, 1);
            op(32'(-h - 1), w, 1);
            op(32'(-h - 2), w, 1);
            op(32'(h), w, 0);
            op(32'(h + 1), w, 0);
        end
        // R10: clear alone, then clear with a clamp at the same edge.
        idle(1, 1);
        idle(2);
        op(32'h8000_0000, 4, 0, 1);
        idle(1, 1);
        // R5 and R11 extremes in unsigned mode.
        op(32'hFFFF_FFFF, 31, 0);
        op(32'h7FFF_FFFF, 31, 0);
        op(32'h8000_0000, 31, 1);
        op(32'h0000_0001, 0, 0);
        op(32'hFFFF_FFFF, 0, 1);
        // Back-to-back operations with a random mix.
        @(negedge clk);
        for (int i = 0; i < 400; i++) begin
            in_valid = ($urandom % 4) != 0;
            in_value = $urandom;
            if ($urandom % 3 == 0) in_value = 32'($signed(in_value) >>> ($urandom % 32));
            in_width = 5'($urandom % 32);
            in_signed = $urandom % 2;
            sticky_clr = ($urandom % 8) == 0;
            @(negedge clk);
        end
        in_valid = 0; sticky_clr = 0;
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule